// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a processor three 8-bit parallel ports, called A, B and C, behind a small register interface. The processor writes a configuration word that sets the direction and operating mode of each port. The basic mode is plain latched output or direct pin input. The strobed mode adds a handshake with the peripheral. Port A also has a bidirectional mode that carries both handshakes at once. When a port runs a handshake, some port C pins stop acting as general I/O and carry that port's strobe, acknowledge, buffer flags and interrupt request. The remaining port C pins stay general I/O in two 4-bit halves.

The processor side uses an active-low chip select, active-low read and write strobes, a 2-bit address and 8-bit data buses. Each access lasts one clock cycle and is sampled on the clock. Pins are modelled as separate input, output and per-bit output-enable vectors, and the pad logic builds the tri-state drivers from these. A short command sent to the control address sets or clears a single port C latch bit. The same bit-wise command also controls the interrupt-enable flags of the handshake ports.

Top module: `ppi_core`

## Requirements
- R1: After reset no pin is driven: pa_oe_o, pb_oe_o and pc_oe_o are all zero. A read of address 3 returns 0x9B.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A write to 3 with bit 7 = 1 is a configuration word with these fields:
  - bits 6:5: port A mode (00 basic, 01 strobed, 1x bidirectional)
  - bit 4: port A input
  - bit 3: upper half of port C input
  - bit 2: port B strobed
  - bit 1: port B input
  - bit 0: lower half of port C input

  In basic mode, an output port drives the value last written to it. Reading an input port returns its pins.
- R3: A configuration write clears the port A and port B output latches, all port C latch bits (which clears every interrupt enable) and every buffer-full flag.
- R4: A write to address 3 with bit 7 = 0 sets port C latch bit data[3:1] to data[0] and leaves the configuration unchanged.
- R5: The upper (PC7..PC4) and lower (PC3..PC0) halves of port C each take their own direction from configuration bits 3 and 0.
- R6: Strobed input on port A uses PC4 as the strobe, PC5 as the buffer-full output and PC3 as the interrupt request. On port B, PC2 is the strobe, PC1 the buffer-full output and PC0 the interrupt request. In both cases a low strobe latches the port pins and sets buffer-full, and a processor read of the port returns the latched byte and clears buffer-full.
- R7: Strobed output on port A uses PC7 as the active-low output-buffer-full signal and PC6 as the acknowledge. On port B, PC1 is the output-buffer-full signal and PC2 the acknowledge. A processor write to the port drives the output-buffer-full signal low, and a low acknowledge drives it high again.
- R8: The interrupt request (PC3 for A, PC0 for B) is high when the port's buffer condition holds and its enable bit is set:
  - for input, the condition is buffer-full, and the enable is PC4 latch (A) or PC2 latch (B).
  - for output, the condition is output buffer empty, and the enable is PC6 latch (A) or PC2 latch (B).
- R9: In bidirectional mode, port A runs the R6 and R7 handshakes together. It drives its pins only while PC6 is low.
- R10: The handshake pins for port B are PC2..PC0 for both input and output. Handshake input pins are never driven, handshake output pins are always driven, and the other port C pins follow the direction of their half.
- R11: A read of port C returns:
  - the live handshake outputs on handshake output pins;
  - the interrupt-enable latch bit on handshake input pins;
  - the latch on general output pins;
  - the pin value on general input pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register select |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, zero outside reads |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A pins out |
| pa_oe_o | output | 1 | Port A output enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B pins out |
| pb_oe_o | output | 1 | Port B output enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C pins out |
| pc_oe_o | output | 8 | Port C per-bit output enable |

## Verification
The assertions assume these input conditions:
- a processor access is a single cycle in which read and write strobes are never low together;
- a peripheral strobe or acknowledge is seen only while the port is configured for that handshake;
- a configuration write is never combined with a handshake event in the same cycle.

The stimulus drives every input one nanosecond after the rising edge. It holds PC2, PC4 and PC6 high except for deliberate one-cycle pulses or a held acknowledge, and it issues accesses strictly one after another. A behavioural model of registers and flags is compared with every output on each falling edge.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;
  typedef enum logic [1:0] {
    A_BASIC   = 2'd0,
    A_STROBED = 2'd1,
    A_BIDIR   = 2'd2
  } a_mode_e;

  typedef struct packed {
    logic       is_cfg;
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_strobed;
    logic       b_in;
    logic       cl_in;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h9B;

  function automatic a_mode_e a_mode_of(logic [1:0] f);
    if (f[1]) return A_BIDIR;
    return f[0] ? A_STROBED : A_BASIC;
  endfunction
endpackage

// File: rtl/ppi_ctrl.sv
`timescale 1ns/1ps
module ppi_ctrl import ppi_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic          wr_pc_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] pc_q_o,
  output logic          cfg_clr_o
);
  localparam int IW = $clog2(DW);

  ctrl_t         ctrl_q;
  logic [DW-1:0] pc_q;

  assign cfg_clr_o = wr_ctrl_i & wdata_i[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
      pc_q   <= '0;
    end else if (cfg_clr_o) begin
      ctrl_q <= ctrl_t'(wdata_i);
      pc_q   <= '0;
    end else if (wr_ctrl_i) begin
      pc_q[wdata_i[IW:1]] <= wdata_i[0];
    end else if (wr_pc_i) begin
      pc_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign pc_q_o = pc_q;

  AST_BSR_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !wdata_i[DW-1]) |=> $stable(ctrl_q)); // R4
  AST_CFG_CLEARS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clr_o |=> (pc_q == '0)); // R3
endmodule

// File: rtl/ppi_hs_port.sv
`timescale 1ns/1ps
module ppi_hs_port #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          in_en_i,
  input  logic          out_en_i,
  input  logic          stb_ni,
  input  logic          ack_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] in_q_o,
  output logic [DW-1:0] out_q_o,
  output logic          ibf_o,
  output logic          obf_o
);
  logic [DW-1:0] in_q, out_q;
  logic          ibf_q, obf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else if (clr_i) begin
      out_q <= '0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else begin
      if (in_en_i && !stb_ni) begin
        in_q  <= pin_i;
        ibf_q <= 1'b1;
      end else if (rd_i) begin
        ibf_q <= 1'b0;
      end
      if (wr_i) begin
        out_q <= wdata_i;
        if (out_en_i) obf_q <= 1'b1;
      end else if (out_en_i && !ack_ni) begin
        obf_q <= 1'b0;
      end
    end
  end

  assign in_q_o  = in_q;
  assign out_q_o = out_q;
  assign ibf_o   = ibf_q;
  assign obf_o   = obf_q;

  AST_STB_SETS_IBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_en_i && !stb_ni && !clr_i) |=> ibf_o); // R6
  AST_ACK_CLEARS_OBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && !ack_ni && !wr_i && !clr_i) |=> !obf_o); // R7
  AST_CLR_DROPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ibf_o && !obf_o && out_q_o == '0)); // R3
endmodule

// File: rtl/ppi_core.sv
`timescale 1ns/1ps
module ppi_core import ppi_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic          pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic          pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam logic [1:0] SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CTL = 2'd3;
  // port C handshake pin positions
  localparam int PC_INTR_B = 0, PC_HS_B = 1, PC_STB_B = 2, PC_INTR_A = 3;
  localparam int PC_STB_A = 4, PC_IBF_A = 5, PC_ACK_A = 6, PC_OBF_A = 7;
  localparam int PC_SPLIT = DW / 2;

  ctrl_t         ctrl;
  a_mode_e       a_mode;
  logic [DW-1:0] pc_q, a_in_q, a_out_q, b_in_q, b_out_q;
  logic [DW-1:0] hs_out, hs_in, hs_val, pc_rd;
  logic          cfg_clr, wr_acc, rd_acc;
  logic          a_in_hs, a_out_hs, b_in_hs, b_out_hs;
  logic          ibf_a, obf_a, ibf_b, obf_b, intr_a, intr_b;

  assign wr_acc = ~cs_ni & ~wr_ni;
  assign rd_acc = ~cs_ni & ~rd_ni & ~wr_acc;

  ppi_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_ctrl_i(wr_acc && addr_i == SEL_CTL),
    .wr_pc_i  (wr_acc && addr_i == SEL_C),
    .wdata_i  (data_i),
    .ctrl_o   (ctrl),
    .pc_q_o   (pc_q),
    .cfg_clr_o(cfg_clr)
  );

  assign a_mode   = a_mode_of(ctrl.a_mode);
  assign a_in_hs  = (a_mode == A_STROBED && ctrl.a_in) || a_mode == A_BIDIR;
  assign a_out_hs = (a_mode == A_STROBED && !ctrl.a_in) || a_mode == A_BIDIR;
  assign b_in_hs  = ctrl.b_strobed & ctrl.b_in;
  assign b_out_hs = ctrl.b_strobed & ~ctrl.b_in;

  ppi_hs_port #(.DW(DW)) u_port_a (
    .clk_i, .rst_ni, .clr_i(cfg_clr),
    .in_en_i(a_in_hs), .out_en_i(a_out_hs),
    .stb_ni(pc_i[PC_STB_A]), .ack_ni(pc_i[PC_ACK_A]),
    .wr_i(wr_acc && addr_i == SEL_A), .rd_i(rd_acc && addr_i == SEL_A),
    .wdata_i(data_i), .pin_i(pa_i),
    .in_q_o(a_in_q), .out_q_o(a_out_q), .ibf_o(ibf_a), .obf_o(obf_a)
  );

  ppi_hs_port #(.DW(DW)) u_port_b (
    .clk_i, .rst_ni, .clr_i(cfg_clr),
    .in_en_i(b_in_hs), .out_en_i(b_out_hs),
    .stb_ni(pc_i[PC_STB_B]), .ack_ni(pc_i[PC_STB_B]),
    .wr_i(wr_acc && addr_i == SEL_B), .rd_i(rd_acc && addr_i == SEL_B),
    .wdata_i(data_i), .pin_i(pb_i),
    .in_q_o(b_in_q), .out_q_o(b_out_q), .ibf_o(ibf_b), .obf_o(obf_b)
  );

  // enable latches sit on the handshake input positions
  assign intr_a = (a_in_hs & pc_q[PC_STB_A] & ibf_a) | (a_out_hs & pc_q[PC_ACK_A] & ~obf_a);
  assign intr_b = ctrl.b_strobed & pc_q[PC_STB_B] & (ctrl.b_in ? ibf_b : ~obf_b);

  always_comb begin
    hs_out = '0;
    hs_in  = '0;
    hs_val = '0;
    if (a_in_hs)  begin hs_out[PC_IBF_A] = 1'b1; hs_out[PC_INTR_A] = 1'b1; hs_in[PC_STB_A] = 1'b1; end
    if (a_out_hs) begin hs_out[PC_OBF_A] = 1'b1; hs_out[PC_INTR_A] = 1'b1; hs_in[PC_ACK_A] = 1'b1; end
    if (ctrl.b_strobed) begin
      hs_out[PC_HS_B] = 1'b1; hs_out[PC_INTR_B] = 1'b1; hs_in[PC_STB_B] = 1'b1;
    end
    hs_val[PC_INTR_A] = intr_a;
    hs_val[PC_IBF_A]  = ibf_a;
    hs_val[PC_OBF_A]  = ~obf_a;
    hs_val[PC_INTR_B] = intr_b;
    hs_val[PC_HS_B]   = ctrl.b_in ? ibf_b : ~obf_b;
  end

  for (genvar g = 0; g < DW; g++) begin : g_pc
    logic half_out;
    assign half_out   = (g >= PC_SPLIT) ? ~ctrl.cu_in : ~ctrl.cl_in;
    assign pc_oe_o[g] = hs_out[g] | (~hs_in[g] & half_out);
    assign pc_o[g]    = hs_out[g] ? hs_val[g] : pc_q[g];
    assign pc_rd[g]   = hs_out[g] ? hs_val[g]
                      : ((hs_in[g] | pc_oe_o[g]) ? pc_q[g] : pc_i[g]);
  end

  assign pa_o    = a_out_q;
  assign pa_oe_o = (a_mode == A_BIDIR) ? ~pc_i[PC_ACK_A] : ~ctrl.a_in;
  assign pb_o    = b_out_q;
  assign pb_oe_o = ~ctrl.b_in;

  always_comb begin
    data_o = '0;
    if (rd_acc) begin
      unique case (addr_i)
        SEL_A:   data_o = a_in_hs ? a_in_q : (ctrl.a_in ? pa_i : a_out_q);
        SEL_B:   data_o = b_in_hs ? b_in_q : (ctrl.b_in ? pb_i : b_out_q);
        SEL_C:   data_o = pc_rd;
        default: data_o = ctrl;
      endcase
    end
  end

  AST_BIDIR_DRIVES_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode == A_BIDIR && pa_oe_o) |-> !pc_i[PC_ACK_A]); // R9
  AST_BASIC_IN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode == A_BASIC && ctrl.a_in) |-> !pa_oe_o); // R2
  AST_HS_IN_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.b_strobed |-> !pc_oe_o[PC_STB_B]); // R10
endmodule

// File: tb/ppi_core_test.sv
`timescale 1ns/1ps
module ppi_core_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00, pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] data_o, pa_o, pb_o, pc_o, pc_oe;
  logic       pa_oe, pb_oe;
  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ppi_core uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(data_o),
    .pa_i(pa_in), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_in), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_in), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  // behavioural reference state
  logic [7:0] mc, mpc, ma_out, mb_out, ma_in, mb_in;
  bit mibfa, mobfa, mibfb, mobfb;

  function automatic int amode(logic [7:0] c);
    return c[6] ? 2 : (c[5] ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = 8'h9B; mpc = 0; ma_out = 0; mb_out = 0; ma_in = 0; mb_in = 0;
      mibfa = 0; mobfa = 0; mibfb = 0; mobfb = 0;
    end else begin
      automatic bit wr = !cs_n && !wr_n;
      automatic bit rd = !cs_n && !rd_n && !wr;
      automatic int am = amode(mc);
      automatic bit ain = (am == 1 && mc[4]) || am == 2;
      automatic bit aout = (am == 1 && !mc[4]) || am == 2;
      automatic bit bin = mc[2] && mc[1];
      automatic bit bout = mc[2] && !mc[1];
      if (wr && addr == 3 && din[7]) begin
        mc = din; mpc = 0; ma_out = 0; mb_out = 0;
        mibfa = 0; mobfa = 0; mibfb = 0; mobfb = 0;
      end else begin
        if (wr && addr == 3) mpc[din[3:1]] = din[0];
        if (wr && addr == 2) mpc = din;
        if (ain && !pc_in[4]) begin ma_in = pa_in; mibfa = 1; end
        else if (rd && addr == 0) mibfa = 0;
        if (wr && addr == 0) begin ma_out = din; if (aout) mobfa = 1; end
        else if (aout && !pc_in[6]) mobfa = 0;
        if (bin && !pc_in[2]) begin mb_in = pb_in; mibfb = 1; end
        else if (rd && addr == 1) mibfb = 0;
        if (wr && addr == 1) begin mb_out = din; if (bout) mobfb = 1; end
        else if (bout && !pc_in[2]) mobfb = 0;
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    automatic int am = amode(mc);
    automatic bit ain = (am == 1 && mc[4]) || am == 2;
    automatic bit aout = (am == 1 && !mc[4]) || am == 2;
    automatic bit bh = mc[2];
    automatic logic [7:0] so = 0, si = 0, sv = 0, eoe, epc, erd, ed;
    automatic bit rd = !cs_n && !rd_n && wr_n;
    if (ain)  begin so[5] = 1; so[3] = 1; si[4] = 1; end
    if (aout) begin so[7] = 1; so[3] = 1; si[6] = 1; end
    if (bh)   begin so[1] = 1; so[0] = 1; si[2] = 1; end
    sv[3] = (ain && mpc[4] && mibfa) || (aout && mpc[6] && !mobfa);
    sv[5] = mibfa;
    sv[7] = !mobfa;
    sv[0] = bh && mpc[2] && (mc[1] ? mibfb : !mobfb);
    sv[1] = mc[1] ? mibfb : !mobfb;
    for (int i = 0; i < 8; i++) begin
      eoe[i] = so[i] || (!si[i] && !(i >= 4 ? mc[3] : mc[0]));
      epc[i] = so[i] ? sv[i] : mpc[i];
      erd[i] = so[i] ? sv[i] : ((si[i] || eoe[i]) ? mpc[i] : pc_in[i]);
    end
    ed = 0;
    if (rd) case (addr)
      2'd0: ed = ain ? ma_in : (mc[4] ? pa_in : ma_out);
      2'd1: ed = (bh && mc[1]) ? mb_in : (mc[1] ? pb_in : mb_out);
      2'd2: ed = erd;
      default: ed = mc;
    endcase
    check("R2 pa_o", pa_o, ma_out);
    check("R9 pa_oe", {7'b0, pa_oe}, {7'b0, (am == 2) ? !pc_in[6] : !mc[4]});
    check("R2 pb_o", pb_o, mb_out);
    check("R2 pb_oe", {7'b0, pb_oe}, {7'b0, !mc[1]});
    check("R10 pc_oe", pc_oe, eoe);
    check("R11 pc_o", pc_o & pc_oe, epc & eoe);
    check("R11 data_o", data_o, ed);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1 cs_n = 0; wr_n = 0; addr = a; din = d;
    @(posedge clk); #1 cs_n = 1; wr_n = 1;
  endtask

  task automatic cpu_rd(logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1 cs_n = 0; rd_n = 0; addr = a;
    @(negedge clk); d = data_o;
    @(posedge clk); #1 cs_n = 1; rd_n = 1;
  endtask

  task automatic pc_pulse(int b);
    @(posedge clk); #1 pc_in[b] = 1'b0;
    @(posedge clk); #1 pc_in[b] = 1'b1;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 pa_oe", {7'b0, pa_oe}, 8'h00);
    check("R1 pb_oe", {7'b0, pb_oe}, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    cpu_rd(2'd3, r); check("R1 ctrl", r, 8'h9B);

    // basic mode, all out
    cpu_wr(3, 8'h80); @(negedge clk);
    check("R2 all out", {pa_oe, pb_oe, 6'b0}, 8'hC0);
    check("R2 pc_oe", pc_oe, 8'hFF);
    cpu_wr(0, 8'h5A); cpu_wr(2, 8'h3C); @(negedge clk);
    check("R2 pa drive", pa_o, 8'h5A);
    check("R2 pc drive", pc_o, 8'h3C);
    cpu_wr(3, 8'h88); @(negedge clk);
    check("R5 upper in", pc_oe, 8'h0F);
    check("R3 pa cleared", pa_o, 8'h00);
    cpu_wr(3, 8'h81); @(negedge clk);
    check("R5 lower in", pc_oe, 8'hF0);
    cpu_wr(3, 8'h80);
    cpu_wr(3, 8'h0B); cpu_wr(3, 8'h01); @(negedge clk);
    check("R4 bsr set", pc_o, 8'h21);
    cpu_wr(3, 8'h0A); @(negedge clk);
    check("R4 bsr clear", pc_o, 8'h01);
    cpu_rd(3, r); check("R4 cfg kept", r, 8'h80);

    // basic input
    cpu_wr(3, 8'h9B); pa_in = 8'hC3; pb_in = 8'h77;
    cpu_rd(0, r); check("R2 read pa", r, 8'hC3);
    cpu_rd(1, r); check("R2 read pb", r, 8'h77);

    // port A strobed input
    cpu_wr(3, 8'hB0); @(negedge clk);
    check("R10 pc roles A in", pc_oe, 8'hEF);
    cpu_wr(3, 8'h09);
    cpu_rd(2, r); check("R11 status idle", r, 8'h10);
    pa_in = 8'h96; pc_pulse(4); @(negedge clk);
    check("R6 ibf A", {7'b0, pc_o[5]}, 8'h01);
    check("R8 intr A in", {7'b0, pc_o[3]}, 8'h01);
    pa_in = 8'h00;
    cpu_rd(2, r); check("R11 status full", r, 8'h38);
    cpu_rd(0, r); check("R6 latched A", r, 8'h96);
    @(negedge clk);
    check("R6 ibf A cleared", {6'b0, pc_o[5], pc_o[3]}, 8'h00);

    // port A strobed output
    cpu_wr(3, 8'hA0); @(negedge clk);
    check("R3 obf idle", {6'b0, pc_o[7], pc_o[3]}, 8'h02);
    cpu_wr(3, 8'h0D); @(negedge clk);
    check("R8 intr A out", {7'b0, pc_o[3]}, 8'h01);
    cpu_wr(0, 8'hE1); @(negedge clk);
    check("R7 obf A low", {6'b0, pc_o[7], pc_o[3]}, 8'h00);
    check("R7 pa data", pa_o, 8'hE1);
    pc_pulse(6); @(negedge clk);
    check("R7 ack A", {6'b0, pc_o[7], pc_o[3]}, 8'h03);

    // port B strobed input, then output
    cpu_wr(3, 8'h86); @(negedge clk);
    check("R10 pc roles B in", pc_oe, 8'hFB);
    cpu_wr(3, 8'h05); pb_in = 8'h42; pc_pulse(2); @(negedge clk);
    check("R6 ibf/intr B", {6'b0, pc_o[1], pc_o[0]}, 8'h03);
    cpu_rd(1, r); check("R6 latched B", r, 8'h42);
    cpu_wr(3, 8'h84); @(negedge clk);
    check("R10 pc roles B out", pc_oe, 8'hFB);
    check("R7 obf B idle", {7'b0, pc_o[1]}, 8'h01);
    cpu_wr(1, 8'h18); @(negedge clk);
    check("R7 obf B low", {7'b0, pc_o[1]}, 8'h00);
    check("R7 pb data", pb_o, 8'h18);
    pc_pulse(2); @(negedge clk);
    check("R7 ack B", {7'b0, pc_o[1]}, 8'h01);

    // port A bidirectional
    cpu_wr(3, 8'hC0); @(negedge clk);
    check("R9 idle undriven", {7'b0, pa_oe}, 8'h00);
    check("R10 pc roles bidir", pc_oe, 8'hAF);
    cpu_wr(0, 8'h3E); @(negedge clk);
    check("R9 obf low", {7'b0, pc_o[7]}, 8'h00);
    @(posedge clk); #1 pc_in[6] = 1'b0;
    @(negedge clk);
    check("R9 drive on ack", {7'b0, pa_oe}, 8'h01);
    check("R9 data on ack", pa_o, 8'h3E);
    @(posedge clk); #1 pc_in[6] = 1'b1;
    @(negedge clk);
    check("R9 released", {pa_oe, pc_o[7], 6'b0}, 8'h40);
    pa_in = 8'h71; pc_pulse(4); @(negedge clk);
    check("R9 ibf", {7'b0, pc_o[5]}, 8'h01);
    cpu_rd(0, r); check("R9 read in", r, 8'h71);

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule